// File: doc/BRIEF.md
# One-Hot Selected Register File Array

This block holds a small set of identical storage registers, each of a configurable width, behind a single write port and a single read port. Instead of a binary address, every register has its own write-enable bit and its own read-enable bit, so the caller presents one-hot enable vectors. A write is captured into the selected register on the rising clock edge. The read path has no register stage: each register drives its stored value onto a private output while its read-enable is high and drives zero otherwise.

Because every unselected register outputs zero, the per-register outputs are merged by a bitwise OR-reduction tree rather than a multiplexer. Selecting several registers for reading at once is therefore legal and yields the OR of their contents. A static parameter chooses whether a read and a write that target the same register in the same cycle return the incoming write data (write-through) or the value stored before the edge.

The block is meant to be placed where a pipeline already owns one-hot register selects, such as operand collectors that decode destination fields upstream.

Top module: `onehot_regfile`

## Requirements
- R1: When bit i of `wr_sel` is 1 and `rst_n` is 1 at a rising edge, register i holds `wr_data` after that edge.
- R2: A register whose `wr_sel` bit is 0 at a rising edge keeps its value across that edge; writing one register never alters any other.
- R3: The read is combinational: with a single `rd_sel` bit i set, `rd_data` equals register i's current content in the same cycle, with no clock edge in between.
- R4: When `rd_sel` is all zeros, `rd_data` is exactly zero.
- R5: When several `rd_sel` bits are 1, `rd_data` is the bitwise OR of the selected registers' contents.
- R6: With `WRITE_THRU` = 1, if bit i is set in both `rd_sel` and `wr_sel` in the same cycle, register i contributes `wr_data` to `rd_data` in that cycle.
- R7: With `WRITE_THRU` = 0, a same-cycle read and write of register i returns the value stored before the edge; the new value appears on the read from the next cycle on.
- R8: Reset is synchronous and active low: a rising edge with `rst_n` = 0 clears every register to zero and ignores `wr_sel`, and `rd_data` is zero while `rst_n` is 0.
- R9: `wr_sel` must be one-hot or all zeros while out of reset (input constraint checked by an assertion).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_sel | input | COUNT | One-hot write enable, bit i selects register i |
| wr_data | input | WIDTH | Data loaded into the selected register |
| rd_sel | input | COUNT | Read enable per register, bit i selects register i |
| rd_data | output | WIDTH | OR of all enabled register outputs |

## Verification
The read port is driven with empty selects, single-bit selects and random multi-bit selects, which separate the zero-idle case, correct per-register routing and the OR merge respectively. Reads that coincide with a write to the same register are run on a pass-through and a non-pass-through instance side by side, telling the bypass path apart from the stored value. A full sweep of single reads after a long random write phase shows whether any write disturbed a register it did not select, and writes held during reset show that reset wins over the write select.

// File: rtl/onehot_regfile_pkg.sv
// Package: onehot_regfile_pkg
// Shared helpers for the one-hot register file. Assumes sizes are small
// enough that a power-of-two rounding fits in 32 bits.
package onehot_regfile_pkg;

    // Smallest power of two that is >= n (n >= 1).
    function automatic int unsigned pow2_ceil(input int unsigned n);
        int unsigned p;
        p = 1;
        while (p < n) p = p << 1;
        return p;
    endfunction

endpackage

// File: rtl/onehot_regfile_cell.sv
// Module: onehot_regfile_cell
// One storage register with its own write enable and read enable.
// The read output is combinational and is zero unless the read enable is
// high and reset is released. BYPASS=1 forwards write data to the read
// output when both enables are high in the same cycle.
// Assumes: a synchronous active-low reset applied for at least one edge.
module onehot_regfile_cell #(
    parameter int unsigned WIDTH  = 64,
    parameter bit          BYPASS = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store_q;
    logic [WIDTH-1:0] read_src;
    logic             read_ok;

    // Capture write data on the edge; reset clears and overrides writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (we) begin
            store_q <= wdata;
        end
    end

    // Pick the value offered to the read path (static variant choice).
    generate
        if (BYPASS) begin : g_thru
            assign read_src = we ? wdata : store_q;
        end else begin : g_plain
            assign read_src = store_q;
        end
    endgenerate

    // Gate the read output to zero when not selected or in reset.
    assign read_ok = re & rst_n;

    always_comb begin
        rdata = read_ok ? read_src : '0;
    end

    AST_CELL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (store_q == $past(wdata)));                        // R1
    AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(store_q));                                // R2
    AST_CELL_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !re |-> (rdata == '0));                                   // R4

endmodule

// File: rtl/onehot_regfile_or_tree.sv
// Module: onehot_regfile_or_tree
// Balanced bitwise OR reduction of LEAVES words. Missing leaves up to the
// next power of two are tied to zero. Assumes LEAVES >= 1.
module onehot_regfile_or_tree
    import onehot_regfile_pkg::*;
#(
    parameter int unsigned WIDTH  = 64,
    parameter int unsigned LEAVES = 8
) (
    input  logic [LEAVES-1:0][WIDTH-1:0] leaf_i,
    output logic [WIDTH-1:0]             root_o
);

    localparam int unsigned SLOTS = pow2_ceil(LEAVES);
    localparam int unsigned NODES = 2 * SLOTS;

    // Heap-indexed node array: node 1 is the root, SLOTS.. are leaves.
    logic [WIDTH-1:0] node [1:NODES-1];

    generate
        // Fill the leaf level, padding unused slots with zero.
        for (genvar li = 0; li < SLOTS; li++) begin : g_leaf
            if (li < LEAVES) begin : g_used
                assign node[SLOTS+li] = leaf_i[li];
            end else begin : g_pad
                assign node[SLOTS+li] = '0;
            end
        end
        // Each inner node merges its two children.
        for (genvar ni = 1; ni < SLOTS; ni++) begin : g_inner
            assign node[ni] = node[2*ni] | node[2*ni+1];
        end
    endgenerate

    assign root_o = node[1];

endmodule

// File: rtl/onehot_regfile.sv
// Module: onehot_regfile (top)
// COUNT registers of WIDTH bits with one write port and one read port,
// both selected by per-register enable bits. Unselected registers read as
// zero, so the read port is an OR tree over all register outputs.
// WRITE_THRU selects same-cycle forwarding of write data to the read.
// Assumes: wr_sel is one-hot or zero; rd_sel may have several bits set.
module onehot_regfile #(
    parameter int unsigned WIDTH      = 64,
    parameter int unsigned COUNT      = 8,
    parameter bit          WRITE_THRU = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [COUNT-1:0] wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [COUNT-1:0] rd_sel,
    output logic [WIDTH-1:0] rd_data
);

    logic [COUNT-1:0][WIDTH-1:0] cell_out;

    // One cell per register, each owning one enable bit of each port.
    generate
        for (genvar ci = 0; ci < COUNT; ci++) begin : g_cell
            onehot_regfile_cell #(
                .WIDTH  (WIDTH),
                .BYPASS (WRITE_THRU)
            ) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (wr_sel[ci]),
                .wdata (wr_data),
                .re    (rd_sel[ci]),
                .rdata (cell_out[ci])
            );
        end
    endgenerate

    // Merge all gated read outputs into the port output.
    onehot_regfile_or_tree #(
        .WIDTH  (WIDTH),
        .LEAVES (COUNT)
    ) u_merge (
        .leaf_i (cell_out),
        .root_o (rd_data)
    );

    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));                                        // R9
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == '0) |-> (rd_data == '0));                      // R4

    // Reset keeps the read port quiet regardless of the selects.
    always_comb begin
        if (rst_n == 1'b0) begin
            AST_RST_QUIET: assert (rd_data == '0);                // R8
        end
    end

    generate
        if (WRITE_THRU) begin : g_chk_thru
            AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
                ($onehot(wr_sel) && (rd_sel == wr_sel)) |-> (rd_data == wr_data)); // R6
        end else begin : g_chk_plain
            AST_NEXT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
                ($onehot(wr_sel) && (rd_sel == wr_sel)) |=>
                ((rd_sel != $past(rd_sel)) || (wr_sel != '0) || (rd_data == $past(wr_data)))); // R7
        end
    endgenerate

endmodule

// File: tb/tb_onehot_regfile.sv
module tb_onehot_regfile;

    localparam int unsigned WIDTH = 64;
    localparam int unsigned COUNT = 8;

    logic             clk;
    logic             rst_n;
    logic [COUNT-1:0] wr_sel;
    logic [WIDTH-1:0] wr_data;
    logic [COUNT-1:0] rd_sel;
    logic [WIDTH-1:0] rd_plain;
    logic [WIDTH-1:0] rd_thru;

    logic [WIDTH-1:0] model [COUNT];
    int checks;
    int fails;

    onehot_regfile #(.WIDTH(WIDTH), .COUNT(COUNT), .WRITE_THRU(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_plain));

    onehot_regfile #(.WIDTH(WIDTH), .COUNT(COUNT), .WRITE_THRU(1'b1)) dut_thru (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_thru));

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Expected read value from the model and the current inputs.
    function automatic logic [WIDTH-1:0] expect_read(input logic thru);
        logic [WIDTH-1:0] acc;
        acc = '0;
        if (rst_n) begin
            for (int i = 0; i < COUNT; i++) begin
                if (rd_sel[i]) begin
                    if (thru && wr_sel[i]) acc = acc | wr_data;
                    else                   acc = acc | model[i];
                end
            end
        end
        return acc;
    endfunction

    function automatic string read_tag(input logic thru);
        if (!rst_n)                    return "R8";
        if (rd_sel == '0)              return "R4";
        if ((rd_sel & wr_sel) != '0)   return thru ? "R6" : "R7";
        if ($countones(rd_sel) > 1)    return "R5";
        return "R3";
    endfunction

    task automatic check(input string tag, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check reads, then commit model.
    task automatic step(input logic rst_v, input logic [COUNT-1:0] ws,
                        input logic [WIDTH-1:0] wd, input logic [COUNT-1:0] rs);
        @(negedge clk);
        rst_n   = rst_v;
        wr_sel  = ws;
        wr_data = wd;
        rd_sel  = rs;
        #2;
        check(read_tag(1'b0), rd_plain, expect_read(1'b0));
        check(read_tag(1'b1), rd_thru,  expect_read(1'b1));
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < COUNT; i++) model[i] = '0;
        end else begin
            for (int i = 0; i < COUNT; i++) if (wr_sel[i]) model[i] = wr_data;
        end
    endtask

    function automatic logic [WIDTH-1:0] rnd_word();
        return {$urandom(), $urandom()};
    endfunction

    function automatic logic [COUNT-1:0] rnd_one_or_zero();
        int unsigned k;
        k = $urandom_range(0, COUNT);
        return (k == COUNT) ? '0 : (COUNT'(1) << k);
    endfunction

    initial begin
        checks = 0;
        fails  = 0;
        void'($urandom(32'd2024));
        rst_n = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
        for (int i = 0; i < COUNT; i++) model[i] = 'x;

        // R8: reset with a write and all reads requested; write is ignored.
        step(1'b0, 8'b0000_1000, 64'hDEAD_BEEF_0000_0001, '1);
        step(1'b0, 8'b0000_0001, 64'h1234, '1);
        // R8: after reset every register reads zero.
        for (int i = 0; i < COUNT; i++) step(1'b1, '0, '0, COUNT'(1) << i);

        // R1/R3: write register 3, then read it the next cycle.
        step(1'b1, 8'b0000_1000, 64'hA5A5_0000_FFFF_1234, '0);
        step(1'b1, '0, '0, 8'b0000_1000);
        check("R1", rd_plain, 64'hA5A5_0000_FFFF_1234);
        // R6/R7: read and write register 5 together, then read it alone.
        step(1'b1, 8'b0010_0000, 64'h0F0F_0F0F_0F0F_0F0F, 8'b0010_0000);
        step(1'b1, '0, '0, 8'b0010_0000);
        check("R7", rd_plain, 64'h0F0F_0F0F_0F0F_0F0F);
        // R5: read registers 3 and 5 together.
        step(1'b1, '0, '0, 8'b0010_1000);
        check("R5", rd_thru, 64'hA5A5_0000_FFFF_1234 | 64'h0F0F_0F0F_0F0F_0F0F);
        // R4: no read selected while writing.
        step(1'b1, 8'b1000_0000, '1, '0);
        check("R4", rd_plain, '0);

        // Random phase: mixed read select shapes.
        for (int n = 0; n < 3000; n++) begin
            logic [COUNT-1:0] rs;
            int unsigned pick;
            pick = $urandom_range(0, 99);
            if (pick < 15)      rs = '0;
            else if (pick < 75) rs = rnd_one_or_zero();
            else                rs = COUNT'($urandom());
            step(1'b1, rnd_one_or_zero(), rnd_word(), rs);
        end

        // R2: sweep every register alone with no writes; nothing was disturbed.
        for (int i = 0; i < COUNT; i++) begin
            step(1'b1, '0, '0, COUNT'(1) << i);
            check("R2", rd_plain, model[i]);
        end

        // R8: reset in the middle of traffic clears everything.
        step(1'b0, 8'b0000_0100, rnd_word(), 8'b0000_0100);
        for (int i = 0; i < COUNT; i++) begin
            step(1'b1, '0, '0, COUNT'(1) << i);
            check("R8", rd_plain, '0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule